// File: doc/BRIEF.md
# Switchable-Priority Bus Arbiter

This block is the central arbiter of a PCI host bridge. It serves five request/grant pairs. Device 0 is the bridge's own bus master, and devices 1 to 4 are external masters. Requests and grants are active low. At most one grant is driven low in any cycle. Grants are registered, so a decision made from the inputs of one cycle appears on the grant lines after the next rising clock edge.

A mode input chooses between two schemes. In fixed mode the lowest-numbered requester wins. In rotating mode the arbiter keeps a least-recently-granted list. Each device that wins is moved to the tail of that list, and the other devices keep their relative order. The grant can move only when the bus is idle, when the current owner has dropped its request, or when nothing is granted. When nobody requests, the grant parks on device 0. A host-enable input, normally tied to a strap that is sampled at power-on, turns the arbitration function off completely.

Top module: `pbus_arbiter`

## Requirements
- R1: While reset is asserted every grant line is high. Reset loads the rotating list with the order 0,1,2,3,4, with device 0 first. In the first cycle after reset, with the host enabled and no requests, device 0 is granted (`gnt_n` = 5'b11110).
- R2: At most one bit of `gnt_n` is low in any cycle. Bit i belongs to device i.
- R3: In fixed mode (`rr_mode`=0), when re-arbitration is allowed, the requester with the lowest index is granted.
- R4: In rotating mode (`rr_mode`=1), when re-arbitration is allowed, the requester that stands earliest in the rotating list is granted.
- R5: Each grant issued in rotating mode moves the winner to the tail of the list. The other entries keep their relative order, so the list behaves as least-recently-granted and not as a rotating pointer.
- R6: While the bus is busy (`bus_idle`=0) and the granted device still requests, the grant does not change.
- R7: Re-arbitration is allowed when `bus_idle`=1, when the granted device's request is high, or when no grant is active.
- R8: When re-arbitration is allowed and no request is low, the grant parks on device 0.
- R9: With `host_en`=0, every grant line is high from the next cycle on, whatever the state of `rr_mode` and the requests.
- R10: The rotating list changes only on grants issued in rotating mode. Switching the mode keeps its contents, so rotating mode resumes from the order it had when it was left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 5 | Request lines, active low, bit i from device i |
| rr_mode | input | 1 | 0 selects fixed priority, 1 selects least-recently-granted rotation |
| host_en | input | 1 | 1 enables arbitration. 0 withholds all grants |
| bus_idle | input | 1 | 1 when no transaction is in progress on the bus |
| gnt_n | output | 5 | Grant lines, active low, at most one low |

## Verification
The hardest case to reach is a rotating list that a simple pointer would not produce. The list has to be reordered by asymmetric request patterns. For example, granting device 3 alone and then letting 1, 3 and 4 compete shows whether 1 or 4 is preferred. The bench reaches this through sequences of single-cycle idle arbitrations after a fresh reset. It also switches to fixed mode and back in the middle of such a sequence, to show that the list survives. Holding the grant needs the bus kept busy while a higher-priority device requests, and the hand-off is then released either by the owner dropping its request or by idle.

// File: rtl/pbus_arb_pkg.sv
package pbus_arb_pkg;
  localparam int ARB_N = 5;
  localparam int IDX_W = $clog2(ARB_N);

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [ARB_N-1:0] vec_t;
  typedef idx_t [ARB_N-1:0] order_t;  // entry 0 is the highest rank

  function automatic order_t order_init();
    order_t o;
    for (int i = 0; i < ARB_N; i++) o[i] = idx_t'(i);
    return o;
  endfunction

  function automatic idx_t lowest_req(vec_t r);
    idx_t k = '0;
    for (int i = ARB_N - 1; i >= 0; i--) if (r[i]) k = idx_t'(i);
    return k;
  endfunction

  function automatic idx_t first_in_order(order_t o, vec_t r);
    idx_t k = '0;
    for (int i = ARB_N - 1; i >= 0; i--) if (r[o[i]]) k = o[i];
    return k;
  endfunction

  // remove w from the list and append it at the tail
  function automatic order_t retire(order_t o, idx_t w);
    order_t n;
    int p = 0;
    for (int i = 0; i < ARB_N; i++) if (o[i] == w) p = i;
    for (int i = 0; i < ARB_N - 1; i++) n[i] = (i < p) ? o[i] : o[i+1];
    n[ARB_N-1] = w;
    return n;
  endfunction
endpackage

// File: rtl/pbus_prio_list.sv
module pbus_prio_list
  import pbus_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   retire_en,
  input  idx_t   retire_idx,
  output order_t order_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         order_q <= order_init();
    else if (retire_en) order_q <= retire(order_q, retire_idx);
  end
endmodule

// File: rtl/pbus_winner.sv
module pbus_winner
  import pbus_arb_pkg::*;
(
  input  vec_t   req,
  input  logic   rr_mode,
  input  order_t order,
  output logic   any_req,
  output idx_t   win
);
  always_comb begin
    any_req = |req;
    win     = rr_mode ? first_in_order(order, req) : lowest_req(req);
  end
endmodule

// File: rtl/pbus_grant_ctl.sv
module pbus_grant_ctl
  import pbus_arb_pkg::*;
#(
  parameter int PARK_DEV = 0
)(
  input  logic clk,
  input  logic rst_n,
  input  logic host_en,
  input  logic bus_idle,
  input  vec_t req,
  input  logic any_req,
  input  idx_t win,
  output vec_t gnt_q,
  output logic rearb,
  output logic new_grant
);
  localparam vec_t PARK_HOT = vec_t'(1) << PARK_DEV;

  vec_t win_hot;
  vec_t gnt_d;
  logic owner_released;
  logic no_owner;

  for (genvar g = 0; g < ARB_N; g++) begin : g_hot
    assign win_hot[g] = (win == idx_t'(g));
  end

  assign owner_released = |(gnt_q & ~req);
  assign no_owner       = ~|gnt_q;
  assign rearb          = bus_idle | owner_released | no_owner;
  assign new_grant      = host_en & rearb & any_req;

  always_comb begin
    if (!host_en)   gnt_d = '0;
    else if (rearb) gnt_d = any_req ? win_hot : PARK_HOT;
    else            gnt_d = gnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= '0;
    else        gnt_q <= gnt_d;
  end
endmodule

// File: rtl/pbus_arbiter.sv
module pbus_arbiter
  import pbus_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ARB_N-1:0] req_n,
  input  logic             rr_mode,
  input  logic             host_en,
  input  logic             bus_idle,
  output logic [ARB_N-1:0] gnt_n
);
  vec_t   req;
  vec_t   gnt_q;
  order_t order_q;
  idx_t   win;
  logic   any_req;
  logic   rearb;
  logic   new_grant;
  logic   retire_en;

  assign req       = ~req_n;
  assign retire_en = new_grant & rr_mode;
  assign gnt_n     = ~gnt_q;

  pbus_prio_list u_list (
    .clk(clk), .rst_n(rst_n), .retire_en(retire_en),
    .retire_idx(win), .order_q(order_q)
  );

  pbus_winner u_win (
    .req(req), .rr_mode(rr_mode), .order(order_q),
    .any_req(any_req), .win(win)
  );

  pbus_grant_ctl #(.PARK_DEV(0)) u_gnt (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .bus_idle(bus_idle),
    .req(req), .any_req(any_req), .win(win),
    .gnt_q(gnt_q), .rearb(rearb), .new_grant(new_grant)
  );
endmodule

// File: rtl/pbus_arbiter_chk.sv
module pbus_arbiter_chk
  import pbus_arb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [ARB_N-1:0] req_n,
  input logic             rr_mode,
  input logic             host_en,
  input logic             bus_idle,
  input logic [ARB_N-1:0] gnt_n,
  input logic             rearb
);
  vec_t rq;
  vec_t low_req;
  assign rq      = ~req_n;
  assign low_req = rq & (~rq + vec_t'(1));

  always @(posedge clk) begin
    if (!rst_n) p_reset_idle_r1: assert (gnt_n == '1);
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  p_fixed_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !rr_mode && rearb && rq != '0) |=> ((~gnt_n) == $past(low_req)));

  p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !bus_idle && ((~gnt_n & rq) != '0)) |=> $stable(gnt_n));

  p_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && rearb && rq == '0) |=> (gnt_n == ~vec_t'(1)));

  p_host_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !host_en |=> (gnt_n == '1));
endmodule

bind pbus_arbiter pbus_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .rr_mode(rr_mode),
  .host_en(host_en), .bus_idle(bus_idle), .gnt_n(gnt_n), .rearb(rearb)
);

// File: tb/pbus_arbiter_tb.sv
module pbus_arbiter_tb;
  localparam int CLK_P = 10;
  localparam int N = 5;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [N-1:0] req_n = '1;
  logic         rr_mode = 0;
  logic         host_en = 1;
  logic         bus_idle = 1;
  logic [N-1:0] gnt_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state: last-grant stamps (smaller = longer ago), expected grant
  int           stamp_of[N];
  int           stamp_ctr;
  logic [N-1:0] exp_g;

  always #(CLK_P/2) clk = ~clk;

  pbus_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .rr_mode(rr_mode),
    .host_en(host_en), .bus_idle(bus_idle), .gnt_n(gnt_n)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: gnt_n=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) stamp_of[i] = i;
    stamp_ctr = N;
    exp_g = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_n = '1; host_en = 1; bus_idle = 1; rr_mode = 0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R1 in reset", gnt_n, '1);
    rst_n = 1;
  endtask

  // drive one cycle of inputs (requests active high here), then compare
  task automatic step(input logic [N-1:0] rq, input bit mode, input bit host,
                      input bit idle, input string tag);
    bit rearb;
    int w;
    req_n = ~rq; rr_mode = mode; host_en = host; bus_idle = idle;
    rearb = idle || (exp_g == '0) || ((exp_g & ~rq) != '0);
    if (!host) exp_g = '0;
    else if (rearb) begin
      if (rq == '0) exp_g = 5'b00001;
      else begin
        w = -1;
        for (int i = 0; i < N; i++)
          if (rq[i] && (w < 0 || (mode && stamp_of[i] < stamp_of[w]))) w = i;
        if (mode) begin stamp_of[w] = stamp_ctr; stamp_ctr++; end
        exp_g = 5'b00001 << w;
      end
    end
    @(negedge clk);
    check(tag, gnt_n, ~exp_g);
    checks++;
    if ($countones(~gnt_n) > 1) begin
      fails++;
      $display("FAIL R2: gnt_n=%b expected at most one low", gnt_n);
    end
  endtask

  task automatic t_reset_park();
    do_reset();
    step(5'b00000, 0, 1, 1, "R1 park after reset");
    step(5'b00000, 0, 1, 0, "R8 stays parked");
  endtask

  task automatic t_fixed();
    step(5'b11110, 0, 1, 1, "R3 lowest of 1-4");
    step(5'b11111, 0, 1, 1, "R3 all request");
    step(5'b11000, 0, 1, 1, "R3 3 and 4");
    step(5'b10100, 0, 1, 1, "R3 2 and 4");
  endtask

  task automatic t_hold_handoff();
    step(5'b10000, 0, 1, 1, "R7 grant 4");
    step(5'b10011, 0, 1, 0, "R6 hold while busy");
    step(5'b10011, 0, 1, 0, "R6 hold again");
    step(5'b00011, 0, 1, 0, "R7 owner released");
    step(5'b00110, 0, 1, 0, "R6 hold 1 busy");
    step(5'b00111, 0, 1, 1, "R7 idle handoff");
    step(5'b00000, 0, 1, 0, "R8 park on release");
  endtask

  task automatic t_rr_cycle();
    do_reset();
    for (int k = 0; k < 6; k++) step(5'b11111, 1, 1, 1, "R4 rotate all");
  endtask

  task automatic t_rr_lrg();
    do_reset();
    step(5'b01000, 1, 1, 1, "R4 only 3");
    step(5'b11010, 1, 1, 1, "R5 1 before 4");   // pointer scheme would pick 4
    step(5'b11000, 1, 1, 1, "R5 4 before 3");
    step(5'b11011, 1, 1, 1, "R5 0 first");
    step(5'b11111, 1, 1, 1, "R5 2 now first");
  endtask

  task automatic t_mode_switch();
    do_reset();
    step(5'b00001, 1, 1, 1, "R4 grant 0");
    step(5'b00010, 1, 1, 1, "R4 grant 1");
    step(5'b00011, 0, 1, 1, "R10 fixed ignores list");
    step(5'b00011, 0, 1, 1, "R10 fixed again");
    step(5'b11111, 1, 1, 1, "R10 list kept: 2");
    step(5'b00011, 1, 1, 1, "R10 list kept: 0");
  endtask

  task automatic t_host_off();
    step(5'b11111, 1, 0, 1, "R9 off rr");
    step(5'b11111, 0, 0, 1, "R9 off fixed");
    step(5'b00000, 0, 0, 1, "R9 off no park");
    step(5'b00100, 0, 1, 1, "R9 back on");
  endtask

  initial begin
    model_reset();
    t_reset_park();
    t_fixed();
    t_hold_handoff();
    t_rr_cycle();
    t_rr_lrg();
    t_mode_switch();
    t_host_off();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule